// File: doc/BRIEF.md
# Lane-Keyed Feistel Cipher Core

This block is an iterative 32-bit block cipher keyed by a 64-bit value. Its round is a Feistel step of the SIMON kind, working on two 16-bit halves. A caller presents an input word, a key and a 2-bit lane number together with a start strobe. The core takes them in only when it is idle. It then runs one round per clock for 32 clocks and raises a one-cycle done strobe with the 32-bit result.

The key is grown into 32 round keys while the rounds run. One step of the schedule is taken per round from a sliding window of four words. The lane number rotates which round key is used inside every aligned group of four, so one key yields four different ciphers. A group register keeps the four words of the current group fixed while the window moves ahead.

Top module: `lane_feistel_core`

## Requirements
- R1: After reset, `busy`, `done` and `dout` are all zero.
- R2: The key is cut into four 16-bit words, the first taken from bits 63..48, then 47..32, then 31..16, then 15..0. These are round keys 0 to 3.
- R3: Round key n+4 (n = 0..27) is 0xFFFC XOR z XOR key[n] XOR t XOR ror16(t,1). Here t = ror16(key[n+3],3) XOR key[n+1], and z is bit (63 - n) of 0xFA2561CDF44AC398.
- R4: Round i uses key[4*(i/4) + ((i mod 4 + lane) mod 4)]. The four lane values 0, 1, 2 and 3 give four distinct results for the same key and input.
- R5: The starting left half is input bits 15..0 and the starting right half is input bits 31..16. The result is {final right, final left}, with right in bits 31..16.
- R6: Each round sets left to right XOR ((rol16(L,1) AND rol16(L,8)) XOR rol16(L,2)) XOR round key, and sets right to the old left.
- R7: A start seen while idle is accepted on that clock edge, and `busy` is high from the next cycle. `done` rises exactly 32 cycles after the accepting edge, together with `busy` falling.
- R8: `done` is high for one cycle only. `dout` changes only when `done` rises and holds its value until the next completion.
- R9: A start while `busy` is high has no effect on the run in progress or its result.
- R10: `din`, `key` and `lane` are sampled only on the accepting edge. Changing them during a run does not change its result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request to begin a run, taken only while idle |
| din | input | 32 | Input block |
| key | input | 64 | Cipher key |
| lane | input | 2 | Lane number selecting the round-key rotation |
| busy | output | 1 | High while the rounds run |
| done | output | 1 | One-cycle strobe marking a valid result |
| dout | output | 32 | Result, held until the next completion |

## Verification
The assertions rely on the inputs being steady around the rising edge. They also rely on reset being released with no run in progress, so that the round counter and the group register start from a known point. The bench changes every input only on the falling clock edge. It holds reset low for several cycles before the first start. It also deliberately drives start during runs and in the done cycle, and changes din, key and lane in mid-run, to exercise the rules for acceptance and sampling.

// File: rtl/lfc_pkg.sv
package lfc_pkg;
    localparam int HALF_W  = 16;
    localparam int BLK_W   = 2 * HALF_W;
    localparam int KWORDS  = 4;
    localparam int KEY_W   = KWORDS * HALF_W;
    localparam int LANE_W  = $clog2(KWORDS);

    localparam logic [KEY_W-1:0]  ZSEQ    = 64'hFA2561CDF44AC398;
    localparam logic [HALF_W-1:0] SCHED_C = 16'hFFFC;

    typedef logic [HALF_W-1:0] half_t;
    typedef logic [KWORDS-1:0][HALF_W-1:0] kwin_t;

    function automatic half_t rotl(input half_t v, input int n);
        return half_t'(v << n) | half_t'(v >> (HALF_W - n));
    endfunction

    function automatic half_t rotr(input half_t v, input int n);
        return half_t'(v >> n) | half_t'(v << (HALF_W - n));
    endfunction
endpackage

// File: rtl/lfc_key_step.sv
module lfc_key_step
    import lfc_pkg::*;
(
    input  half_t k_base,
    input  half_t k_next,
    input  half_t k_last,
    input  logic  zbit,
    output half_t k_new
);
    half_t mix;

    always_comb begin
        mix   = rotr(k_last, 3) ^ k_next;
        k_new = SCHED_C ^ {{(HALF_W-1){1'b0}}, zbit} ^ k_base ^ mix ^ rotr(mix, 1);
    end
endmodule

// File: rtl/lfc_lane_sel.sv
module lfc_lane_sel
    import lfc_pkg::*;
#(
    parameter int GROUP = KWORDS
) (
    input  logic [GROUP-1:0][HALF_W-1:0] grp,
    input  logic [$clog2(GROUP)-1:0]      pos,
    input  logic [$clog2(GROUP)-1:0]      lane,
    output half_t                         rkey
);
    localparam int SEL_W = $clog2(GROUP);
    logic [SEL_W-1:0] idx;

    always_comb begin
        idx  = SEL_W'(pos + lane);
        rkey = grp[idx];
    end
endmodule

// File: rtl/lfc_round.sv
module lfc_round
    import lfc_pkg::*;
(
    input  half_t l_in,
    input  half_t r_in,
    input  half_t rkey,
    output half_t l_out,
    output half_t r_out
);
    half_t fval;

    always_comb begin
        fval  = (rotl(l_in, 1) & rotl(l_in, 8)) ^ rotl(l_in, 2);
        l_out = r_in ^ fval ^ rkey;
        r_out = l_in;
    end
endmodule

// File: rtl/lane_feistel_core.sv
module lane_feistel_core
    import lfc_pkg::*;
#(
    parameter int ROUNDS = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [BLK_W-1:0]  din,
    input  logic [KEY_W-1:0]  key,
    input  logic [LANE_W-1:0] lane,
    output logic              busy,
    output logic              done,
    output logic [BLK_W-1:0]  dout
);
    localparam int CNT_W = $clog2(ROUNDS);
    localparam int ZI_W  = $clog2(KEY_W);

    typedef struct packed {
        logic              busy;
        logic              done;
        logic [CNT_W-1:0]  cnt;
        logic [LANE_W-1:0] lane;
        half_t             l;
        half_t             r;
        kwin_t             kw;
        kwin_t             kg;
        logic [BLK_W-1:0]  dout;
    } state_t;

    state_t s_q, s_d;

    half_t            k_new, rkey, l_nx, r_nx;
    logic [ZI_W-1:0]  zidx;
    kwin_t            key_words;

    always_comb begin
        for (int j = 0; j < KWORDS; j++) begin
            key_words[j] = key[KEY_W-1-HALF_W*j -: HALF_W];
        end
        zidx = ZI_W'(KEY_W - 1) - ZI_W'(s_q.cnt);
    end

    lfc_key_step i_step (
        .k_base (s_q.kw[0]),
        .k_next (s_q.kw[1]),
        .k_last (s_q.kw[3]),
        .zbit   (ZSEQ[zidx]),
        .k_new  (k_new)
    );

    lfc_lane_sel #(.GROUP(KWORDS)) i_sel (
        .grp  (s_q.kg),
        .pos  (s_q.cnt[LANE_W-1:0]),
        .lane (s_q.lane),
        .rkey (rkey)
    );

    lfc_round i_round (
        .l_in  (s_q.l),
        .r_in  (s_q.r),
        .rkey  (rkey),
        .l_out (l_nx),
        .r_out (r_nx)
    );

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        if (s_q.busy) begin
            s_d.l = l_nx;
            s_d.r = r_nx;
            for (int j = 0; j < KWORDS - 1; j++) begin
                s_d.kw[j] = s_q.kw[j+1];
            end
            s_d.kw[KWORDS-1] = k_new;
            if (&s_q.cnt[LANE_W-1:0]) begin
                s_d.kg = s_d.kw;
            end
            if (s_q.cnt == CNT_W'(ROUNDS - 1)) begin
                s_d.busy = 1'b0;
                s_d.done = 1'b1;
                s_d.cnt  = '0;
                s_d.dout = {r_nx, l_nx};
            end else begin
                s_d.cnt = s_q.cnt + 1'b1;
            end
        end else if (start) begin
            s_d.busy = 1'b1;
            s_d.cnt  = '0;
            s_d.lane = lane;
            s_d.l    = din[HALF_W-1:0];
            s_d.r    = din[BLK_W-1:HALF_W];
            s_d.kw   = key_words;
            s_d.kg   = key_words;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign busy = s_q.busy;
    assign done = s_q.done;
    assign dout = s_q.dout;

    // R8: strobe lasts a single cycle
    a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R8: result register moves only at a completion
    a_r8_dout_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |=> $stable(dout));

    // R7: completion follows a run
    a_r7_done_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(busy));

    // R9: a run cannot be cut short, start or not
    a_r9_no_abort: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && s_q.cnt != CNT_W'(ROUNDS - 1)) |=> (busy && !done));

    // R4: group words stay fixed inside a group of four rounds
    a_r4_group_steady: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !(&s_q.cnt[LANE_W-1:0])) |=> $stable(s_q.kg));
endmodule

// File: tb/test_lane_feistel_core.sv
module test_lane_feistel_core;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] din = '0;
    logic [63:0] key = '0;
    logic [1:0]  lane = '0;
    logic        busy, done;
    logic [31:0] dout;

    int total = 0;
    int bad = 0;
    bit finished = 0;
    bit checking = 0;
    string cur_tag = "R1";

    lane_feistel_core i_lane_feistel_core (
        .clk(clk), .rst_n(rst_n), .start(start), .din(din),
        .key(key), .lane(lane), .busy(busy), .done(done), .dout(dout)
    );

    always #4 clk = ~clk;

    function automatic logic [15:0] rl(input logic [15:0] v, input int n);
        logic [31:0] w;
        w = {v, v} << n;
        return w[31:16];
    endfunction

    function automatic logic [31:0] model(input logic [31:0] x, input logic [63:0] k,
                                          input logic [1:0] ln);
        logic [15:0] rk [0:31];
        logic [15:0] t, a, b, f, tmp;
        logic [63:0] zc;
        zc = 64'hFA2561CDF44AC398;
        rk[0] = k[63:48]; rk[1] = k[47:32]; rk[2] = k[31:16]; rk[3] = k[15:0];
        for (int n = 0; n < 28; n++) begin
            t = rl(rk[n+3], 13) ^ rk[n+1];
            rk[n+4] = 16'hFFFC ^ {15'd0, zc[63-n]} ^ rk[n] ^ t ^ rl(t, 15);
        end
        a = x[15:0];
        b = x[31:16];
        for (int i = 0; i < 32; i++) begin
            f = (rl(a, 1) & rl(a, 8)) ^ rl(a, 2);
            tmp = b ^ f ^ rk[(i / 4) * 4 + ((i % 4 + ln) % 4)];
            b = a;
            a = tmp;
        end
        return {b, a};
    endfunction

    bit          exp_busy = 0;
    bit          exp_done = 0;
    logic [31:0] exp_dout = '0;
    logic [31:0] pending = '0;
    int          remaining = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            exp_busy = 0; exp_done = 0; exp_dout = '0; remaining = 0;
        end else begin
            exp_done = 0;
            if (exp_busy) begin
                remaining = remaining - 1;
                if (remaining == 0) begin
                    exp_busy = 0;
                    exp_done = 1;
                    exp_dout = pending;
                end
            end else if (start) begin
                exp_busy = 1;
                remaining = 32;
                pending = model(din, key, lane);
            end
        end
    end

    logic [31:0] last_result = '0;

    always @(negedge clk) begin
        if (rst_n && checking && !finished) begin
            total++;
            if (busy !== exp_busy || done !== exp_done) begin
                bad++;
                $display("FAIL R7 busy/done act=%b/%b exp=%b/%b", busy, done, exp_busy, exp_done);
            end
            total++;
            if (dout !== exp_dout) begin
                bad++;
                $display("FAIL R8/%s dout act=%h exp=%h", cur_tag, dout, exp_dout);
            end
            if (done) last_result = dout;
        end
    end

    task automatic run_one(input logic [31:0] x, input logic [63:0] k,
                           input logic [1:0] ln, input string tag);
        @(negedge clk);
        cur_tag = tag;
        din = x; key = k; lane = ln; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (33) @(negedge clk);
    endtask

    task automatic finish_up();
        if (!finished) begin
            finished = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        #1000000;
        total++;
        bad++;
        $display("FAIL watchdog act=timeout exp=completion");
        finish_up();
    end

    logic [31:0] lane_res [4];

    initial begin
        repeat (4) @(negedge clk);
        total++;
        if (busy !== 1'b0 || done !== 1'b0 || dout !== 32'd0) begin
            bad++;
            $display("FAIL R1 reset act=%b%b%h exp=00%h", busy, done, dout, 32'd0);
        end
        rst_n = 1'b1;
        checking = 1;

        run_one(32'h0, 64'h0, 2'd0, "R3");
        run_one(32'h0, 64'hFFFF_0000_0000_0000, 2'd0, "R2");
        run_one(32'h0, 64'h0000_0000_0000_FFFF, 2'd0, "R2");
        run_one(32'h0000_FFFF, 64'h0, 2'd0, "R5");
        run_one(32'hFFFF_0000, 64'h0, 2'd0, "R5");
        run_one(32'h8001_0001, 64'h0123_4567_89AB_CDEF, 2'd1, "R6");

        for (int ln = 0; ln < 4; ln++) begin
            run_one(32'h6565_6877, 64'h1918_1110_0908_0100, 2'(ln), "R4");
            lane_res[ln] = last_result;
        end
        for (int a = 0; a < 4; a++) begin
            for (int b = a + 1; b < 4; b++) begin
                total++;
                if (lane_res[a] == lane_res[b]) begin
                    bad++;
                    $display("FAIL R4 lanes %0d,%0d act=%h exp=distinct", a, b, lane_res[a]);
                end
            end
        end

        // R9: start pulses and R10: input changes during the run
        @(negedge clk);
        cur_tag = "R9";
        din = 32'hDEAD_BEEF; key = 64'hA5A5_5A5A_0F0F_F0F0; lane = 2'd2; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (5) @(negedge clk);
        start = 1'b1; din = 32'h1234_5678; key = 64'h0; lane = 2'd3;
        @(negedge clk);
        start = 1'b0;
        cur_tag = "R10";
        repeat (10) begin
            @(negedge clk);
            din = din + 32'h1111; key = ~key; lane = lane + 2'd1;
        end
        repeat (20) @(negedge clk);

        // R7: start held high, back-to-back acceptance at the done cycle
        cur_tag = "R7";
        din = 32'hCAFE_F00D; key = 64'h0F1E_2D3C_4B5A_6978; lane = 2'd1;
        start = 1'b1;
        repeat (70) @(negedge clk);
        start = 1'b0;
        repeat (36) @(negedge clk);

        for (int n = 0; n < 20; n++) begin
            run_one($urandom, {$urandom, $urandom}, 2'($urandom), "R6");
        end

        checking = 0;
        finish_up();
    end
endmodule